// File: doc/BRIEF.md
# Dual-Protocol Register Access Slave

This block gives a host access to a small on-chip register file over either an I2C-compatible two-wire bus or a four-wire SPI link. Both protocols share the same clock and data pins. The chip-select pin also picks the protocol. All pins are oversampled by the system clock through two-flop synchronizers. Every bus action is decided on the synchronized edges, so the host clocks must be several system clocks long.

After reset the block acts as an I2C slave. Its 7-bit address is set by two strap inputs. The first falling edge on chip-select switches it to SPI for good, and only a reset brings it back to I2C. In both protocols the host sends a start register address and then streams data bytes. The register pointer steps by one after every byte and wraps at the end of the array. Every write goes out on a one-cycle write strobe and also lands in the internal array.

Top module: `dual_mode_regslave`

## Requirements
- R1: After reset the block is in I2C mode (`spi_active` = 0), releases SDA and keeps `so_oe` low. It stays in I2C mode while `cs_n` is held high.
- R2: A high-to-low edge on `cs_n` sets `spi_active`. It stays set whatever `cs_n` does afterwards, until the next assertion of `rst_n`.
- R3: The I2C slave address is 0x16 plus the 2-bit value {`strap1_in`,`strap0_in`}. The straps are followed only while in I2C mode and are frozen once SPI mode is entered.
- R4: An I2C write is START, address byte with R/W bit 0 = 0, register byte, then data bytes. The slave ACKs every byte by pulling SDA low in the ninth clock. Data byte k goes to register N+k.
- R5: An I2C read is a register-address write, then a repeated START with R/W = 1. The slave then sends register N, N+1, ... MSB first, until the master answers a byte with NACK.
- R6: If the address byte does not match, the slave does not ACK it. It then ignores the bus, with no ACKs and no writes, until the next START.
- R7: An SPI frame is framed by `cs_n` low and works in clock mode 0 or 3. SI is sampled on rising SCK, MSB first. The first byte is a command: bit 7 = 1 for read, 0 for write, and bits 6:0 give the start register. On a write, each later byte is written to successive registers.
- R8: On an SPI read, data is shifted out MSB first on falling SCK, starting at the start register. `so_oe` is low during the command byte and whenever `cs_n` is high.
- R9: The register pointer wraps from the last register (0x7F) to 0x00 on auto-increment, in both protocols.
- R10: While in SPI mode the block never pulls SDA low, so I2C traffic gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_sck | input | 1 | I2C SCL, or SCK in SPI mode |
| sda_si | input | 1 | Resolved SDA line level, or SI in SPI mode |
| cs_n | input | 1 | SPI chip select (active low); its first fall selects SPI |
| strap0_in | input | 1 | Address strap bit 0 (this pin carries SO in SPI mode) |
| strap1_in | input | 1 | Address strap bit 1 |
| sda_pull_low | output | 1 | Open-drain SDA drive: 1 pulls the line low |
| so_out | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for `so_out`; 0 means high impedance |
| spi_active | output | 1 | 1 once SPI mode has been latched |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 7 | Register written when `reg_we` is high |
| reg_wdata | output | 8 | Data written when `reg_we` is high |

## Verification
The assertions check the mode latch on every cycle: it never falls back without a reset, and it cannot be set while chip-select is settled high. They also check that the strap-derived address holds still once SPI mode is entered, and that SO is never enabled outside SPI or with chip-select high. They check as well that SDA is never pulled in SPI mode. Only the bench scenarios can show the byte-level behaviour: ACK/NACK on matching and foreign addresses, repeated-start reads, both SPI clock modes, and pointer wrap at 0x7F. They also cover the strap-to-address mapping and the return to I2C after reset. These are checked against a behavioural memory model and an expected-write queue.

// File: rtl/dm_pkg.sv
`timescale 1ns/1ps
package dm_pkg;

  typedef enum logic [3:0] {
    I_IDLE, I_ADDR, I_AACK, I_REG, I_RACK, I_WR, I_WACK, I_RD, I_MACK
  } i2c_st_e;

  // Pin-strapped 7-bit slave address
  function automatic logic [6:0] strap_to_addr(input logic [6:0] base,
                                               input logic [1:0] strap);
    return base + {5'b0, strap};
  endfunction

endpackage

// File: rtl/dm_pin_sync.sv
`timescale 1ns/1ps
module dm_pin_sync #(
  parameter int          N    = 1,
  parameter logic [N-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= INIT[g];
        s2 <= INIT[g];
        s3 <= INIT[g];
      end else begin
        s1 <= pin[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[g]  = s2;
    assign rise[g] = s2 & ~s3;
    assign fall[g] = ~s2 & s3;
  end
endmodule

// File: rtl/dm_regfile.sv
`timescale 1ns/1ps
module dm_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dm_i2c_engine.sv
`timescale 1ns/1ps
module dm_i2c_engine
  import dm_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [6:0]    dev_addr,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          sda_low
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  i2c_st_e       st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [AW-1:0] ptr;
  logic          rw, nack;

  wire start_evt = scl_lvl & sda_fall;
  wire stop_evt  = scl_lvl & sda_rise;
  wire byte_full = (cnt == FULL);
  wire [DW-1:0] byte_nx = {sh[DW-2:0], sda_lvl};

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= I_IDLE; cnt <= '0; sh <= '0; ptr <= '0; rw <= 1'b0; nack <= 1'b1;
      sda_low <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
    end else if (!en) begin
      st <= I_IDLE; sda_low <= 1'b0; we <= 1'b0; cnt <= '0;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        st <= I_ADDR; cnt <= '0; sda_low <= 1'b0;
      end else if (stop_evt) begin
        st <= I_IDLE; sda_low <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          I_ADDR, I_REG, I_WR: begin sh <= byte_nx; cnt <= cnt + CW'(1); end
          I_RD:                cnt <= cnt + CW'(1);
          I_MACK:              nack <= sda_lvl;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          I_ADDR: if (byte_full) begin
            if (sh[DW-1:1] == dev_addr) begin
              sda_low <= 1'b1; rw <= sh[0]; st <= I_AACK;
            end else begin
              st <= I_IDLE;
            end
          end
          I_REG: if (byte_full) begin
            ptr <= sh[AW-1:0]; sda_low <= 1'b1; st <= I_RACK;
          end
          I_WR: if (byte_full) begin
            we <= 1'b1; waddr <= ptr; wdata <= sh; ptr <= step(ptr);
            sda_low <= 1'b1; st <= I_WACK;
          end
          I_AACK: begin
            cnt <= '0;
            if (rw) begin
              sh <= rd_data; ptr <= step(ptr); sda_low <= ~rd_data[DW-1]; st <= I_RD;
            end else begin
              sda_low <= 1'b0; st <= I_REG;
            end
          end
          I_RACK, I_WACK: begin
            sda_low <= 1'b0; cnt <= '0; st <= I_WR;
          end
          I_RD: begin
            if (byte_full) begin
              sda_low <= 1'b0; st <= I_MACK;
            end else begin
              sh <= {sh[DW-2:0], 1'b0}; sda_low <= ~sh[DW-2];
            end
          end
          I_MACK: begin
            if (nack) begin
              st <= I_IDLE;
            end else begin
              cnt <= '0; sh <= rd_data; ptr <= step(ptr);
              sda_low <= ~rd_data[DW-1]; st <= I_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dm_spi_engine.sv
`timescale 1ns/1ps
module dm_spi_engine #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_lvl,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          so,
  output logic          so_oe
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, osh;
  logic [AW-1:0] ptr;
  logic          cmd_phase, rd_mode, pend;

  wire [DW-1:0] byte_nx   = {sh[DW-2:0], si};
  wire          byte_done = sck_rise && (cnt == LAST);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  assign rd_addr = ptr;
  assign so      = osh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; osh <= '0; ptr <= '0;
      cmd_phase <= 1'b1; rd_mode <= 1'b0; pend <= 1'b0;
      so_oe <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
    end else if (!en || cs_lvl || cs_rise) begin
      cnt <= '0; cmd_phase <= 1'b1; rd_mode <= 1'b0; pend <= 1'b0;
      so_oe <= 1'b0; we <= 1'b0;
    end else begin
      we <= 1'b0;
      if (sck_rise) begin
        sh  <= byte_nx;
        cnt <= cnt + CW'(1);
        if (byte_done) begin
          if (cmd_phase) begin
            cmd_phase <= 1'b0;
            rd_mode   <= byte_nx[DW-1];
            pend      <= byte_nx[DW-1];
            ptr       <= byte_nx[AW-1:0];
          end else if (rd_mode) begin
            pend <= 1'b1;
          end else begin
            we <= 1'b1; waddr <= ptr; wdata <= byte_nx; ptr <= step(ptr);
          end
        end
      end else if (sck_fall && rd_mode) begin
        if (pend) begin
          osh <= rd_data; ptr <= step(ptr); pend <= 1'b0; so_oe <= 1'b1;
        end else begin
          osh <= {osh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/dual_mode_regslave.sv
`timescale 1ns/1ps
module dual_mode_regslave #(
  parameter int         AW        = 7,
  parameter int         DW        = 8,
  parameter logic [6:0] I2C_BASE  = 7'h16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_sck,
  input  logic          sda_si,
  input  logic          cs_n,
  input  logic          strap0_in,
  input  logic          strap1_in,
  output logic          sda_pull_low,
  output logic          so_out,
  output logic          so_oe,
  output logic          spi_active,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata
);
  // synchronized pins: [0]=clock pin, [1]=data pin, [2]=chip select
  logic [2:0] p_lvl, p_rise, p_fall;
  dm_pin_sync #(.N(3), .INIT(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({cs_n, sda_si, scl_sck}),
    .lvl(p_lvl), .rise(p_rise), .fall(p_fall));

  wire cs_lvl  = p_lvl[2];
  wire cs_fall = p_fall[2];

  logic       spi_mode;
  logic [1:0] strap_q;
  wire  [6:0] dev_addr = dm_pkg::strap_to_addr(I2C_BASE, strap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_mode <= 1'b0;
      strap_q  <= 2'b00;
    end else begin
      if (cs_fall) spi_mode <= 1'b1;
      if (!spi_mode) strap_q <= {strap1_in, strap0_in};
    end
  end

  logic [AW-1:0] i_raddr, s_raddr, i_waddr, s_waddr, raddr;
  logic [DW-1:0] i_wdata, s_wdata, rdata;
  logic          i_we, s_we;

  dm_i2c_engine #(.AW(AW), .DW(DW)) u_i2c (
    .clk(clk), .rst_n(rst_n), .en(~spi_mode),
    .scl_lvl(p_lvl[0]), .scl_rise(p_rise[0]), .scl_fall(p_fall[0]),
    .sda_lvl(p_lvl[1]), .sda_rise(p_rise[1]), .sda_fall(p_fall[1]),
    .dev_addr(dev_addr), .rd_data(rdata), .rd_addr(i_raddr),
    .we(i_we), .waddr(i_waddr), .wdata(i_wdata), .sda_low(sda_pull_low));

  dm_spi_engine #(.AW(AW), .DW(DW)) u_spi (
    .clk(clk), .rst_n(rst_n), .en(spi_mode),
    .cs_lvl(cs_lvl), .cs_rise(p_rise[2]),
    .sck_rise(p_rise[0]), .sck_fall(p_fall[0]), .si(p_lvl[1]),
    .rd_data(rdata), .rd_addr(s_raddr),
    .we(s_we), .waddr(s_waddr), .wdata(s_wdata),
    .so(so_out), .so_oe(so_oe));

  assign raddr     = spi_mode ? s_raddr : i_raddr;
  assign reg_we    = spi_mode ? s_we    : i_we;
  assign reg_addr  = spi_mode ? s_waddr : i_waddr;
  assign reg_wdata = spi_mode ? s_wdata : i_wdata;
  assign spi_active = spi_mode;

  dm_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr),
    .wdata(reg_wdata), .raddr(raddr), .rdata(rdata));
endmodule

// File: rtl/dm_regslave_checker.sv
`timescale 1ns/1ps
module dm_regslave_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_active,
  input logic       cs_lvl,
  input logic       so_oe,
  input logic       sda_pull_low,
  input logic [6:0] dev_addr
);
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_active |=> spi_active); // R2

  AST_STAY_I2C_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_active && cs_lvl) |=> !spi_active); // R1

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_active && $past(spi_active)) |-> $stable(dev_addr)); // R3

  AST_SO_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && $past(cs_lvl)) |-> !so_oe); // R8

  AST_SO_ONLY_IN_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> spi_active); // R8

  AST_SDA_QUIET_IN_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_active && $past(spi_active)) |-> !sda_pull_low); // R10
endmodule

bind dual_mode_regslave dm_regslave_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_active(spi_active), .cs_lvl(cs_lvl),
  .so_oe(so_oe), .sda_pull_low(sda_pull_low), .dev_addr(dev_addr));

// File: tb/sim_dual_mode_regslave.sv
`timescale 1ns/1ps
module sim_dual_mode_regslave;
  localparam int H = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, cs_n = 1'b1, st0 = 1'b0, st1 = 1'b0;
  logic sda_pull_low, so_out, so_oe, spi_active, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  wire  sda_line = ~(m_low | sda_pull_low);

  dual_mode_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_sck(scl), .sda_si(sda_line), .cs_n(cs_n),
    .strap0_in(st0), .strap1_in(st1), .sda_pull_low(sda_pull_low),
    .so_out(so_out), .so_oe(so_oe), .spi_active(spi_active),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [128];
  int exp_q [$];
  bit exp_spi = 0;
  int cs_hi = 0, cs_lo = 0;
  bit done = 0;

  function automatic void chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endfunction

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_spi = 0; cs_hi = 0; cs_lo = 0;
    end else begin
      if (cs_n) begin cs_hi++; cs_lo = 0; end else begin cs_lo++; cs_hi = 0; end
      if (cs_lo >= 4) exp_spi = 1;
      if (cs_hi >= 4 || cs_lo >= 4) chk("R2 mode", spi_active, exp_spi);
      if (cs_hi >= 4) chk("R8 so_oe deselected", so_oe, 0);
      if (exp_spi && (cs_hi >= 4 || cs_lo >= 4)) chk("R10 sda in spi", sda_pull_low, 0);
      if (reg_we) begin
        if (exp_q.size() == 0) chk("R4/R7 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk("R4/R7 write", {reg_addr, reg_wdata}, e);
        end
      end
    end
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic void expect_wr(logic [6:0] a, logic [7:0] d);
    exp_q.push_back({a, d});
    mem[a] = d;
  endfunction

  // ---------------- I2C master ----------------
  task automatic i2c_start();
    m_low = 0; wclk(H); scl = 1; wclk(H); m_low = 1; wclk(H); scl = 0; wclk(H);
  endtask
  task automatic i2c_stop();
    m_low = 1; wclk(H); scl = 1; wclk(H); m_low = 0; wclk(H);
  endtask
  task automatic i2c_send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wclk(H); scl = 1; wclk(H); scl = 0; wclk(2);
    end
    m_low = 0; wclk(H); scl = 1; wclk(2); ack = (sda_line == 1'b0); wclk(H - 2); scl = 0; wclk(2);
  endtask
  task automatic i2c_recv(input bit mack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      wclk(H); scl = 1; wclk(2); b[i] = sda_line; wclk(H - 2); scl = 0;
    end
    wclk(2); m_low = mack; wclk(H); scl = 1; wclk(H); scl = 0; wclk(2); m_low = 0;
  endtask
  task automatic i2c_write(input logic [6:0] da, input logic [6:0] ra,
                           input logic [23:0] d, input int n, input string req);
    bit a;
    i2c_start();
    i2c_send({da, 1'b0}, a); chk(req, a, 1);
    i2c_send({1'b0, ra}, a); chk(req, a, 1);
    for (int k = 0; k < n; k++) begin
      expect_wr(7'(ra + k), d[8*k +: 8]);
      i2c_send(d[8*k +: 8], a); chk(req, a, 1);
    end
    i2c_stop();
  endtask
  task automatic i2c_read(input logic [6:0] da, input logic [6:0] ra,
                          input int n, input string req);
    bit a;
    logic [7:0] b;
    i2c_start();
    i2c_send({da, 1'b0}, a); chk(req, a, 1);
    i2c_send({1'b0, ra}, a); chk(req, a, 1);
    i2c_start();
    i2c_send({da, 1'b1}, a); chk(req, a, 1);
    for (int k = 0; k < n; k++) begin
      i2c_recv(k != n - 1, b);
      chk(req, b, mem[7'(ra + k)]);
    end
    i2c_stop();
  endtask
  task automatic i2c_probe(input logic [6:0] da, input bit exp_ack, input string req);
    bit a;
    i2c_start(); i2c_send({da, 1'b0}, a); chk(req, a, exp_ack); i2c_stop();
  endtask

  // ---------------- SPI master ----------------
  task automatic spi_begin(input bit m3);
    scl = m3; m_low = 0; wclk(H); cs_n = 0; wclk(H);
  endtask
  task automatic spi_end();
    wclk(H); cs_n = 1; wclk(2 * H); m_low = 0;
  endtask
  task automatic spi_byte(input bit m3, input logic [7:0] tx,
                          output logic [7:0] rx, output int oe_cnt);
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      if (m3) scl = 0;
      m_low = ~tx[i]; wclk(H);
      rx[i] = so_out; oe_cnt += so_oe;
      scl = 1; wclk(H);
      if (!m3) scl = 0;
    end
  endtask
  task automatic spi_write(input bit m3, input logic [6:0] ra,
                           input logic [23:0] d, input int n);
    logic [7:0] rx;
    int oc;
    spi_begin(m3);
    spi_byte(m3, {1'b0, ra}, rx, oc); chk("R8 cmd hi-z", oc, 0);
    for (int k = 0; k < n; k++) begin
      expect_wr(7'(ra + k), d[8*k +: 8]);
      spi_byte(m3, d[8*k +: 8], rx, oc); chk("R7 write no drive", oc, 0);
    end
    spi_end();
  endtask
  task automatic spi_read(input bit m3, input logic [6:0] ra, input int n, input string req);
    logic [7:0] rx;
    int oc;
    spi_begin(m3);
    spi_byte(m3, {1'b1, ra}, rx, oc); chk("R8 cmd hi-z", oc, 0);
    for (int k = 0; k < n; k++) begin
      spi_byte(m3, 8'h00, rx, oc);
      chk(req, rx, mem[7'(ra + k)]);
      chk("R8 data driven", oc, 8);
    end
    spi_end();
    chk("R8 hi-z after frame", so_oe, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    wclk(5); rst_n = 1; wclk(6);
    chk("R1 reset mode", spi_active, 0);
    chk("R1 reset sda", sda_pull_low, 0);
    chk("R1 reset so_oe", so_oe, 0);

    i2c_write(7'h16, 7'h10, 24'hC3B2A1, 3, "R4");
    i2c_read (7'h16, 7'h10, 3, "R5");
    i2c_write(7'h16, 7'h7F, 24'h006B5A, 2, "R9");
    i2c_read (7'h16, 7'h7E, 3, "R9");

    begin : foreign_addr // R6
      bit a;
      i2c_start();
      i2c_send({7'h17, 1'b0}, a); chk("R6 addr nack", a, 0);
      i2c_send(8'h10, a);         chk("R6 ignored", a, 0);
      i2c_send(8'hEE, a);         chk("R6 ignored", a, 0);
      i2c_stop();
    end
    i2c_read(7'h16, 7'h10, 1, "R6");

    {st1, st0} = 2'b01; i2c_probe(7'h17, 1, "R3"); i2c_probe(7'h16, 0, "R3");
    {st1, st0} = 2'b10; i2c_probe(7'h18, 1, "R3");
    {st1, st0} = 2'b11; i2c_probe(7'h19, 1, "R3"); i2c_probe(7'h18, 0, "R3");
    i2c_write(7'h19, 7'h30, 24'h00005C, 1, "R3");
    i2c_read (7'h19, 7'h30, 1, "R3");
    {st1, st0} = 2'b00;
    chk("R1 still i2c", spi_active, 0);

    spi_write(0, 7'h20, 24'h002211, 2);
    chk("R2 latched", spi_active, 1);
    spi_read(1, 7'h1F, 4, "R8");
    spi_write(1, 7'h7F, 24'h008877, 2);
    spi_read(0, 7'h7F, 2, "R9");
    spi_read(0, 7'h10, 3, "R7");

    st0 = 1; wclk(4);
    scl = 1; m_low = 0; wclk(2 * H);
    i2c_probe(7'h16, 0, "R10");
    chk("R2 sticky", spi_active, 1);

    rst_n = 0; wclk(4);
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    chk("R4/R7 queue drained", exp_q.size(), 0);
    st0 = 0; rst_n = 1; wclk(6);
    chk("R1 after reset", spi_active, 0);
    i2c_write(7'h16, 7'h05, 24'h009F3C, 2, "R1");
    i2c_read (7'h16, 7'h04, 3, "R1");

    wclk(20);
    chk("R4/R7 queue drained", exp_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule